// File: doc/BRIEF.md
# Endpoint DMA Request Sequencer

This block paces an external DMA engine, run in demand mode, against the double-buffered main endpoint of a USB device controller. Software programs one configuration word. It holds an enable bit, a direction bit, a burst-length field and an auto-restart bit. From then on the block raises its request line whenever the endpoint buffer is in the right state. In device-to-memory transfers that means the buffer holds a received packet. In memory-to-device transfers it means the buffer still has room.

The block counts acknowledged byte transfers. It drops the request between bursts and at packet ends. It steps a byte pointer through the two packet buffers. That pointer skips the two-byte buffer header, so the DMA stream carries payload bytes only. The block also recognises an end-of-transfer that comes with an acknowledged strobe. This ends the run, optionally restarts it, and raises a completion pulse. While the acknowledge is low, the main endpoint is forced onto the data path. The serial engine, the packet RAM and the command decoder sit outside the block and appear only as status inputs.

Top module: `dmareq_top`

## Requirements
- R1: The burst field sets the number of acknowledged transfers per request: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 16. After the last transfer of a burst, the request is low for exactly one cycle and then rises again if the other conditions hold.
- R2: The request is high only while the block is enabled and the buffer is ready. With direction bit 0 (device to memory), ready means buffer-full is 1. With direction bit 1 (memory to device), ready means buffer-full is 0.
- R3: In device-to-memory transfers, a transfer that comes with the packet-last input ends the burst early. The request is low for one cycle, and the next assertion starts a complete new burst.
- R4: The byte offset presented for a transfer starts at 2 in each buffer, which skips the header. It rises by one per transfer.
- R5: A buffer is finished by the transfer at offset 65 (64 payload bytes), or by a packet-last transfer in device-to-memory mode. After that transfer, the buffer select toggles and the offset returns to 2, with no software action.
- R6: In memory-to-device mode, a one-cycle send pulse follows the transfer that fills a buffer. It also follows a transfer that carries end-of-transfer, which sends the partial buffer.
- R7: A transfer is acknowledge low together with the read or write strobe low. A transfer with end-of-transfer low clears the enable bit and gives a one-cycle completion pulse on the next cycle. End-of-transfer without both acknowledge and a strobe has no effect.
- R8: With auto-restart set, a terminating transfer still pulses completion, but the enable bit stays 1 and requests resume.
- R9: A configuration write with enable 0 removes the request on the next cycle without a completion pulse. Any configuration write restarts the burst count from zero.
- R10: Main-endpoint select equals the inverse of the acknowledge input.
- R11: After reset, the request, completion, send and enable outputs are 0, the buffer select is 0 and the offset is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cfgWr | input | 1 | Load the configuration fields this cycle |
| cfgEnable | input | 1 | Enable bit to load |
| cfgDirWrite | input | 1 | 1 = memory to device, 0 = device to memory |
| cfgBurst | input | 2 | Burst-length code |
| cfgAutoReload | input | 1 | Restart after termination |
| bufFull | input | 1 | Current endpoint buffer full |
| pktLast | input | 1 | Current byte is the last one of the received packet |
| dmaAckN | input | 1 | DMA acknowledge, active low |
| eotN | input | 1 | End of transfer, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| dmaReq | output | 1 | DMA request |
| doneIrq | output | 1 | Completion pulse |
| dmaOn | output | 1 | Current enable bit |
| mainEpSel | output | 1 | Main endpoint forced onto the data path |
| bufSel | output | 1 | Active buffer of the pair |
| memOffset | output | 7 | Byte offset inside the active buffer |
| pktSend | output | 1 | Buffer ready to send (memory-to-device mode) |

## Verification
The assertions assume that each strobe is low for exactly one cycle per byte and only while acknowledge is low. They also assume that a configuration write never falls in the same cycle as a transfer. The bench drives every transfer as a single acknowledged strobe cycle followed by an idle cycle, and it issues configuration writes only between transfers. The buffer-full input is held steady across each burst. This lets the request's reassertion be observed even after a short packet.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;

  typedef enum logic [1:0] {
    BURST_1  = 2'b00,
    BURST_4  = 2'b01,
    BURST_8  = 2'b10,
    BURST_16 = 2'b11
  } burstSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic step;   // one acknowledged byte while enabled
    logic term;   // that byte also carried end-of-transfer
    logic clear;  // hold the burst counter at zero
  } dpStrobe_t;

  function automatic logic [4:0] burstLen(burstSel_e s);
    case (s)
      BURST_1:  return 5'd1;
      BURST_4:  return 5'd4;
      BURST_8:  return 5'd8;
      default:  return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/dmareq_datapath.sv
module dmareq_datapath
  import dmareq_pkg::*;
#(
  parameter int PKT_BYTES = 64,
  parameter int HDR_BYTES = 2,
  parameter int OFF_W     = $clog2(PKT_BYTES + HDR_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  burstSel_e        burst,
  input  logic             dirWrite,
  input  logic             pktLast,
  output logic             burstEnd,
  output logic             bufEnd,
  output logic             bufSel,
  output logic [OFF_W-1:0] memOffset,
  output logic             pktSend
);

  localparam logic [OFF_W-1:0] OFF_FIRST = OFF_W'(HDR_BYTES);
  localparam logic [OFF_W-1:0] OFF_LAST  = OFF_W'(HDR_BYTES + PKT_BYTES - 1);

  logic [3:0] beatCnt;
  logic [4:0] lenNow;

  assign lenNow   = burstLen(burst);
  assign burstEnd = ({1'b0, beatCnt} == lenNow - 5'd1);
  assign bufEnd   = (memOffset == OFF_LAST) || (!dirWrite && pktLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beatCnt <= '0;
    end else if (strb.clear) begin
      beatCnt <= '0;
    end else if (strb.step) begin
      if (burstEnd || bufEnd || strb.term) beatCnt <= '0;
      else                                 beatCnt <= beatCnt + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufSel    <= 1'b0;
      memOffset <= OFF_FIRST;
      pktSend   <= 1'b0;
    end else begin
      pktSend <= strb.step && dirWrite && (bufEnd || strb.term);
      if (strb.step) begin
        if (bufEnd || strb.term) begin
          bufSel    <= ~bufSel;
          memOffset <= OFF_FIRST;
        end else begin
          memOffset <= memOffset + 1'b1;
        end
      end
    end
  end

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, beatCnt} < lenNow);

  p_off_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memOffset >= OFF_FIRST) && (memOffset <= OFF_LAST));

  p_buf_swap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && bufEnd) |=> (bufSel != $past(bufSel)) && (memOffset == OFF_FIRST));

  p_send_write_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !dirWrite) |=> !pktSend);

endmodule

// File: rtl/dmareq_ctrl.sv
module dmareq_ctrl
  import dmareq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWr,
  input  logic       cfgEnable,
  input  logic       cfgDirWrite,
  input  logic [1:0] cfgBurst,
  input  logic       cfgAutoReload,
  input  logic       bufFull,
  input  logic       dmaAckN,
  input  logic       eotN,
  input  logic       rdN,
  input  logic       wrN,
  input  logic       burstEnd,
  input  logic       bufEnd,
  output dpStrobe_t  strb,
  output burstSel_e  burst,
  output logic       dirWrite,
  output logic       dmaReq,
  output logic       doneIrq,
  output logic       dmaOn
);

  logic autoReload;
  logic reqGap;
  logic bufReady;
  logic byteXfer;

  assign byteXfer   = !dmaAckN && (!rdN || !wrN);
  assign strb.step  = byteXfer && dmaOn && !cfgWr;
  assign strb.term  = strb.step && !eotN;
  assign strb.clear = !dmaOn || cfgWr;

  assign bufReady = dirWrite ? !bufFull : bufFull;
  assign dmaReq   = dmaOn && !reqGap && bufReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmaOn      <= 1'b0;
      dirWrite   <= 1'b0;
      burst      <= BURST_1;
      autoReload <= 1'b0;
      reqGap     <= 1'b0;
      doneIrq    <= 1'b0;
    end else begin
      doneIrq <= 1'b0;
      if (cfgWr) begin
        dmaOn      <= cfgEnable;
        dirWrite   <= cfgDirWrite;
        burst      <= burstSel_e'(cfgBurst);
        autoReload <= cfgAutoReload;
        reqGap     <= 1'b0;
      end else if (strb.term) begin
        dmaOn   <= autoReload;
        doneIrq <= 1'b1;
        reqGap  <= 1'b1;
      end else begin
        reqGap <= strb.step && (burstEnd || bufEnd);
      end
    end
  end

  p_gap_after_burst_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && burstEnd) |=> !dmaReq);

  p_eot_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dmaOn && !cfgWr && !dmaAckN && !eotN && (!rdN || !wrN)) |=> doneIrq);

  p_eot_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dmaOn && !cfgWr && !autoReload && !dmaAckN && !eotN && (!rdN || !wrN)) |=> !dmaOn);

  p_autoreload_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dmaOn && !cfgWr && autoReload && !dmaAckN && !eotN && (!rdN || !wrN)) |=> dmaOn);

  p_sw_stop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && !cfgEnable) |=> (!dmaReq && !doneIrq));

  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);

endmodule

// File: rtl/dmareq_top.sv
module dmareq_top
  import dmareq_pkg::*;
#(
  parameter int PKT_BYTES = 64,
  parameter int HDR_BYTES = 2,
  localparam int OFF_W    = $clog2(PKT_BYTES + HDR_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic             cfgEnable,
  input  logic             cfgDirWrite,
  input  logic [1:0]       cfgBurst,
  input  logic             cfgAutoReload,
  input  logic             bufFull,
  input  logic             pktLast,
  input  logic             dmaAckN,
  input  logic             eotN,
  input  logic             rdN,
  input  logic             wrN,
  output logic             dmaReq,
  output logic             doneIrq,
  output logic             dmaOn,
  output logic             mainEpSel,
  output logic             bufSel,
  output logic [OFF_W-1:0] memOffset,
  output logic             pktSend
);

  dpStrobe_t strb;
  burstSel_e burst;
  logic      dirWrite;
  logic      burstEnd;
  logic      bufEnd;

  assign mainEpSel = !dmaAckN;

  dmareq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWr(cfgWr), .cfgEnable(cfgEnable), .cfgDirWrite(cfgDirWrite),
    .cfgBurst(cfgBurst), .cfgAutoReload(cfgAutoReload),
    .bufFull(bufFull), .dmaAckN(dmaAckN), .eotN(eotN), .rdN(rdN), .wrN(wrN),
    .burstEnd(burstEnd), .bufEnd(bufEnd),
    .strb(strb), .burst(burst), .dirWrite(dirWrite),
    .dmaReq(dmaReq), .doneIrq(doneIrq), .dmaOn(dmaOn)
  );

  dmareq_datapath #(
    .PKT_BYTES(PKT_BYTES), .HDR_BYTES(HDR_BYTES), .OFF_W(OFF_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .burst(burst), .dirWrite(dirWrite),
    .pktLast(pktLast), .burstEnd(burstEnd), .bufEnd(bufEnd),
    .bufSel(bufSel), .memOffset(memOffset), .pktSend(pktSend)
  );

endmodule

// File: tb/dmareq_top_tb.sv
module dmareq_top_tb;

  localparam int PKT = 64;
  localparam int HDR = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWr = 0, cfgEnable = 0, cfgDirWrite = 0, cfgAutoReload = 0;
  logic [1:0] cfgBurst = 0;
  logic bufFull = 0, pktLast = 0;
  logic dmaAckN = 1, eotN = 1, rdN = 1, wrN = 1;
  logic dmaReq, doneIrq, dmaOn, mainEpSel, bufSel, pktSend;
  logic [6:0] memOffset;

  int nChk = 0, nFail = 0;
  bit finished = 0;

  // bench model
  bit expEn = 0, expDir = 0, expAr = 0, expSel = 0;
  int expLen = 1, expCnt = 0, expOff = HDR;

  always #2 clk = ~clk;

  dmareq_top u_dut (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgEnable(cfgEnable),
    .cfgDirWrite(cfgDirWrite), .cfgBurst(cfgBurst), .cfgAutoReload(cfgAutoReload),
    .bufFull(bufFull), .pktLast(pktLast), .dmaAckN(dmaAckN), .eotN(eotN),
    .rdN(rdN), .wrN(wrN), .dmaReq(dmaReq), .doneIrq(doneIrq), .dmaOn(dmaOn),
    .mainEpSel(mainEpSel), .bufSel(bufSel), .memOffset(memOffset), .pktSend(pktSend)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit readyExp();
    return expDir ? !bufFull : bufFull;
  endfunction

  task automatic cfg(input bit en, input bit dir, input int b, input bit ar);
    @(negedge clk);
    cfgWr = 1; cfgEnable = en; cfgDirWrite = dir; cfgBurst = 2'(b); cfgAutoReload = ar;
    @(negedge clk);
    cfgWr = 0;
    expEn = en; expDir = dir; expAr = ar; expCnt = 0;
    expLen = (b == 0) ? 1 : (b == 1) ? 4 : (b == 2) ? 8 : 16;
    #1;
    chk(dmaReq == (en && readyExp()), "R2/R9 request after config", dmaReq, en && readyExp());
    chk(doneIrq == 0, "R9 no completion on config", doneIrq, 0);
  endtask

  task automatic xferByte(input bit lastIn, input bit eotIn);
    bit endBuf, endBurst, gapExp;
    @(negedge clk);
    pktLast = lastIn; eotN = !eotIn; dmaAckN = 0;
    if (expDir) wrN = 0; else rdN = 0;
    #1;
    chk(dmaReq == 1, "R2 request before transfer", dmaReq, 1);
    chk(mainEpSel == 1, "R10 main endpoint during ack", mainEpSel, 1);
    chk(memOffset == 7'(expOff), "R4 byte offset", memOffset, expOff);
    chk(bufSel == expSel, "R5 buffer select", bufSel, expSel);
    @(negedge clk);
    pktLast = 0; eotN = 1; dmaAckN = 1; rdN = 1; wrN = 1;
    #1;
    endBuf   = (expOff == HDR + PKT - 1) || (!expDir && lastIn);
    endBurst = (expCnt == expLen - 1);
    gapExp   = endBuf || endBurst || eotIn;
    if (endBuf || eotIn) begin expSel = !expSel; expOff = HDR; end
    else expOff++;
    expCnt = gapExp ? 0 : expCnt + 1;
    if (eotIn) expEn = expAr;
    chk(mainEpSel == 0, "R10 main endpoint released", mainEpSel, 0);
    chk(dmaReq == (!gapExp && expEn && readyExp()), "R1/R3 request after transfer",
        dmaReq, !gapExp && expEn && readyExp());
    chk(doneIrq == eotIn, "R7 completion pulse", doneIrq, eotIn);
    chk(dmaOn == expEn, "R7/R8 enable bit", dmaOn, expEn);
    if (expDir) chk(pktSend == (endBuf || eotIn), "R6 send pulse", pktSend, endBuf || eotIn);
    if (gapExp) begin
      @(negedge clk); #1;
      chk(dmaReq == (expEn && readyExp()), "R1/R3 request re-armed", dmaReq, expEn && readyExp());
      chk(doneIrq == 0, "R7 completion single cycle", doneIrq, 0);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    chk(dmaReq == 0, "R11 request", dmaReq, 0);
    chk(doneIrq == 0, "R11 completion", doneIrq, 0);
    chk(dmaOn == 0, "R11 enable", dmaOn, 0);
    chk(pktSend == 0, "R11 send", pktSend, 0);
    chk(bufSel == 0, "R11 buffer select", bufSel, 0);
    chk(memOffset == 7'(HDR), "R11 offset", memOffset, HDR);
    @(negedge clk); rstN = 1;

    // R2 read direction waits for a full buffer
    bufFull = 0;
    cfg(1, 0, 0, 0);
    chk(dmaReq == 0, "R2 empty buffer no read request", dmaReq, 0);
    @(negedge clk); bufFull = 1; #1;
    chk(dmaReq == 1, "R2 full buffer read request", dmaReq, 1);

    // R1 sweep every burst code, two bursts each, crossing a buffer end (R5)
    for (int b = 0; b < 4; b++) begin
      cfg(1, 0, b, 0);
      for (int k = 0; k < 2 * expLen; k++) xferByte(0, 0);
    end
    for (int k = 0; k < 40; k++) xferByte(0, 0);

    // R3 short packet cuts a 16-beat burst, then a fresh full burst
    cfg(1, 0, 3, 0);
    xferByte(0, 0); xferByte(0, 0); xferByte(1, 0);
    for (int k = 0; k < 16; k++) xferByte(0, 0);

    // R7 end-of-transfer without a strobe is ignored
    @(negedge clk); dmaAckN = 0; eotN = 0;
    @(negedge clk); dmaAckN = 1; eotN = 1; #1;
    chk(dmaOn == 1, "R7 eot without strobe keeps enable", dmaOn, 1);
    chk(doneIrq == 0, "R7 eot without strobe no completion", doneIrq, 0);
    @(negedge clk); eotN = 0; rdN = 0;
    @(negedge clk); eotN = 1; rdN = 1; #1;
    chk(dmaOn == 1, "R7 eot without ack keeps enable", dmaOn, 1);
    chk(memOffset == 7'(expOff), "R7 eot without ack leaves offset", memOffset, expOff);
    xferByte(0, 1);

    // R2, R6 write direction, full buffer then partial on end-of-transfer
    bufFull = 1;
    cfg(1, 1, 2, 0);
    chk(dmaReq == 0, "R2 full buffer no write request", dmaReq, 0);
    @(negedge clk); bufFull = 0; #1;
    chk(dmaReq == 1, "R2 room in buffer write request", dmaReq, 1);
    for (int k = 0; k < 70; k++) xferByte(k == 10, 0);
    xferByte(0, 1);

    // R8 auto-restart
    bufFull = 1;
    cfg(1, 0, 1, 1);
    xferByte(0, 0); xferByte(0, 0); xferByte(0, 1);
    xferByte(0, 0); xferByte(0, 0);

    // R9 software stop mid-burst, restart counts a full burst
    cfg(1, 0, 1, 0);
    xferByte(0, 0); xferByte(0, 0);
    cfg(0, 0, 1, 0);
    chk(dmaOn == 0, "R9 enable cleared", dmaOn, 0);
    cfg(1, 0, 1, 0);
    for (int k = 0; k < 4; k++) xferByte(0, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule